// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects level-sensitive interrupt lines from devices, one request bit that software sets and clears, and one non-maskable line. It then presents at most one request to the processor, together with the identity of the chosen source. Each maskable source has its own enable bit and a fixed urgency level. A global disable input blocks every maskable source at once. The non-maskable line passes regardless of the enables and the global disable.

A current-level register supports nested handlers. When the processor accepts a request, the old level is saved on a small internal stack and the accepted source's level becomes current. After that, only strictly more urgent sources are presented. A return strobe restores the saved level. With this scheme a disk handler can preempt a network handler, while a source can never re-enter its own handler.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the current level is 0, the software request is clear and all enable bits are clear, so `irq_req` stays low even with every device line high.
- R2: Enable bit k gates source ID k: bit 0 is the software request and bit k is device line k-1. A source whose bit is clear is not presented. A write on `en_wr` takes effect from the next clock edge.
- R3: Among the presentable maskable sources, the one with the highest level is chosen. The default levels are 1 for ID 0, 3 for ID 1, 5 for ID 2, 6 for ID 3 and 7 for ID 4.
- R4: A `swi_wr` write with `swi_val`=1 sets the software request, and one with `swi_val`=0 clears it, from the next clock edge. Acceptance does not clear it.
- R5: `irq_id` encodes the source: 0 is software, k is device line k-1, and N_DEV+1 (5 by default) is the non-maskable line.
- R6: While `glob_dis` is high, no maskable source is presented, in the same cycle.
- R7: The non-maskable line is presented with ID 5 and wins over every maskable source. The enable bits and `glob_dis` do not affect it.
- R8: A maskable source is presented only when its level is strictly greater than `cur_level`.
- R9: `ack` while `irq_req` is high makes the presented source's level current at the next edge. `ack` while `irq_req` is low leaves the level unchanged.
- R10: `rti` restores the level saved by the most recent acceptance, one nesting step at a time. With nothing saved, `cur_level` stays 0. When `rti` and `ack` arrive together, only `rti` acts.
- R11: Device lines are level-sensitive. Dropping a line withdraws its request in the same cycle.
- R12: Accepting the non-maskable request sets `cur_level` to all ones (15). While it is there, nothing is presented, not even the non-maskable line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | N_DEV | Level-sensitive device request lines |
| nmi_irq | input | 1 | Non-maskable request line |
| en_wr | input | 1 | Write strobe for the enable register |
| en_data | input | N_DEV+1 | New enable bits, indexed by source ID |
| swi_wr | input | 1 | Write strobe for the software request |
| swi_val | input | 1 | Value written to the software request |
| glob_dis | input | 1 | Blocks all maskable sources while high |
| ack | input | 1 | Processor accepts the presented request |
| rti | input | 1 | Processor returns from the current handler |
| irq_req | output | 1 | A request is presented |
| irq_id | output | clog2(N_DEV+2) | Identity of the presented source |
| cur_level | output | LVL_W | Current level register |

## Verification
`irq_req` and `irq_id` are combinational on the device lines, the non-maskable line and `glob_dis`, so they are due in the same cycle. The effects of enable writes, software request writes, `ack` and `rti` are due one rising edge later. The bench changes inputs on the falling edge. It samples combinational results 1 ns after the change and before the next rising edge. Results that depend on stored state are sampled 1 ns after the falling edge that follows the edge which stores them. The nesting test climbs through every level up to the non-maskable one, then unwinds the saved levels one at a time.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // operation applied to the current-level stack in one cycle
   typedef enum logic [1:0] {
      LVL_HOLD = 2'b00,
      LVL_PUSH = 2'b01,
      LVL_POP  = 2'b10
   } lvl_op_e;
endpackage

// File: rtl/irq_gate.sv
module irq_gate #(
   parameter int N_SRC = 5,
   parameter int LVL_W = 4,
   parameter logic [N_SRC-1:0][LVL_W-1:0] LEVELS = '0
) (
   input  logic [N_SRC-1:0] raw_req,
   input  logic [N_SRC-1:0] enable,
   input  logic             glob_dis,
   input  logic [LVL_W-1:0] cur_lvl,
   output logic [N_SRC-1:0] elig
);
   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      assign elig[g] = raw_req[g] & enable[g] & ~glob_dis & (LEVELS[g] > cur_lvl);
   end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int N_SRC = 5,
   parameter int LVL_W = 4,
   parameter int ID_W  = 3,
   parameter logic [N_SRC-1:0][LVL_W-1:0] LEVELS = '0,
   parameter bit TIE_LOW_ID = 1'b1
) (
   input  logic [N_SRC-1:0] elig,
   output logic             hit,
   output logic [ID_W-1:0]  id,
   output logic [LVL_W-1:0] lvl
);
   if (TIE_LOW_ID) begin : g_tie_low
      always_comb begin
         hit = 1'b0;
         id  = '0;
         lvl = '0;
         for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && (!hit || LEVELS[i] > lvl)) begin
               hit = 1'b1;
               id  = ID_W'(i);
               lvl = LEVELS[i];
            end
         end
      end
   end else begin : g_tie_high
      always_comb begin
         hit = 1'b0;
         id  = '0;
         lvl = '0;
         for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && (!hit || LEVELS[i] >= lvl)) begin
               hit = 1'b1;
               id  = ID_W'(i);
               lvl = LEVELS[i];
            end
         end
      end
   end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
   import irq_pkg::*;
#(
   parameter int LVL_W = 4,
   parameter int DEPTH = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  lvl_op_e          op,
   input  logic [LVL_W-1:0] new_lvl,
   output logic [LVL_W-1:0] cur_lvl
);
   localparam int SP_W  = $clog2(DEPTH + 1);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [LVL_W-1:0] saved [DEPTH];
   logic [SP_W-1:0]  sp;
   logic [SP_W-1:0]  sp_dec;

   assign sp_dec = sp - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_lvl <= '0;
         sp      <= '0;
         for (int i = 0; i < DEPTH; i++) saved[i] <= '0;
      end else begin
         unique case (op)
            LVL_PUSH: begin
               if (sp != SP_W'(DEPTH)) begin
                  saved[sp[IDX_W-1:0]] <= cur_lvl;
                  sp      <= sp + 1'b1;
                  cur_lvl <= new_lvl;
               end
            end
            LVL_POP: begin
               if (sp != '0) begin
                  cur_lvl <= saved[sp_dec[IDX_W-1:0]];
                  sp      <= sp_dec;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_pkg::*;
#(
   parameter int N_DEV = 4,
   parameter int LVL_W = 4,
   parameter logic [N_DEV:0][LVL_W-1:0] SRC_LEVELS = {4'd7, 4'd6, 4'd5, 4'd3, 4'd1},
   parameter bit TIE_LOW_ID = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_DEV-1:0]              dev_irq,
   input  logic                          nmi_irq,
   input  logic                          en_wr,
   input  logic [N_DEV:0]                en_data,
   input  logic                          swi_wr,
   input  logic                          swi_val,
   input  logic                          glob_dis,
   input  logic                          ack,
   input  logic                          rti,
   output logic                          irq_req,
   output logic [$clog2(N_DEV+2)-1:0]    irq_id,
   output logic [LVL_W-1:0]              cur_level
);
   localparam int N_SRC = N_DEV + 1;
   localparam int ID_W  = $clog2(N_DEV + 2);
   localparam int DEPTH = N_SRC + 1;
   localparam logic [ID_W-1:0]  NMI_ID  = ID_W'(N_SRC);
   localparam logic [LVL_W-1:0] NMI_LVL = {LVL_W{1'b1}};

   if (N_DEV < 1) begin : g_bad_ndev
      $error("N_DEV must be at least 1");
   end
   if (LVL_W < 2) begin : g_bad_lvlw
      $error("LVL_W must be at least 2");
   end
   for (genvar g = 0; g < N_SRC; g++) begin : g_lvl_chk
      if (SRC_LEVELS[g] == '0 || SRC_LEVELS[g] == NMI_LVL) begin : g_bad_lvl
         $error("source levels must lie strictly between 0 and the top level");
      end
   end

   logic [N_SRC-1:0] en_q;
   logic             swi_q;
   logic [N_SRC-1:0] raw_req;
   logic [N_SRC-1:0] elig;
   logic             pick_hit;
   logic [ID_W-1:0]  pick_id;
   logic [LVL_W-1:0] pick_lvl;
   logic             nmi_ok;
   logic [LVL_W-1:0] sel_lvl;
   lvl_op_e          op;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         swi_q <= 1'b0;
      end else begin
         if (en_wr)  en_q  <= en_data;
         if (swi_wr) swi_q <= swi_val;
      end
   end

   assign raw_req = {dev_irq, swi_q};

   irq_gate #(
      .N_SRC (N_SRC),
      .LVL_W (LVL_W),
      .LEVELS(SRC_LEVELS)
   ) u_gate (
      .raw_req (raw_req),
      .enable  (en_q),
      .glob_dis(glob_dis),
      .cur_lvl (cur_level),
      .elig    (elig)
   );

   irq_pick #(
      .N_SRC     (N_SRC),
      .LVL_W     (LVL_W),
      .ID_W      (ID_W),
      .LEVELS    (SRC_LEVELS),
      .TIE_LOW_ID(TIE_LOW_ID)
   ) u_pick (
      .elig(elig),
      .hit (pick_hit),
      .id  (pick_id),
      .lvl (pick_lvl)
   );

   assign nmi_ok  = nmi_irq && (cur_level != NMI_LVL);
   assign irq_req = nmi_ok | pick_hit;
   assign irq_id  = nmi_ok ? NMI_ID : pick_id;
   assign sel_lvl = nmi_ok ? NMI_LVL : pick_lvl;

   always_comb begin
      if (rti)                 op = LVL_POP;
      else if (ack && irq_req) op = LVL_PUSH;
      else                     op = LVL_HOLD;
   end

   irq_lvl_stack #(
      .LVL_W(LVL_W),
      .DEPTH(DEPTH)
   ) u_stack (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (op),
      .new_lvl(sel_lvl),
      .cur_lvl(cur_level)
   );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter int N_DEV = 4,
   parameter int LVL_W = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       nmi_irq,
   input logic                       glob_dis,
   input logic                       ack,
   input logic                       rti,
   input logic                       irq_req,
   input logic [$clog2(N_DEV+2)-1:0] irq_id,
   input logic [LVL_W-1:0]           cur_level
);
   localparam int ID_W = $clog2(N_DEV + 2);
   localparam logic [ID_W-1:0]  NMI_ID  = ID_W'(N_DEV + 1);
   localparam logic [LVL_W-1:0] TOP_LVL = {LVL_W{1'b1}};

   assert_id_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_id <= NMI_ID)) else $error("id out of range");

   assert_gdis_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (glob_dis && irq_req) |-> (irq_id == NMI_ID)) else $error("maskable source passed disable");

   assert_nmi_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_irq && cur_level != TOP_LVL) |-> (irq_req && irq_id == NMI_ID)) else $error("nmi not presented");

   assert_ack_raises_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq_req && !rti) |=> (cur_level > $past(cur_level))) else $error("accept did not raise level");

   assert_level_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack && !rti) |=> $stable(cur_level)) else $error("level moved without strobe");

   assert_rti_lowers_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rti && cur_level != '0) |=> (cur_level < $past(cur_level))) else $error("return did not lower level");

   assert_rti_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rti && cur_level == '0) |=> (cur_level == '0)) else $error("return from empty stack moved level");

   assert_top_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_level == TOP_LVL) |-> !irq_req) else $error("request presented at top level");
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
   .N_DEV(N_DEV),
   .LVL_W(LVL_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .nmi_irq  (nmi_irq),
   .glob_dis (glob_dis),
   .ack      (ack),
   .rti      (rti),
   .irq_req  (irq_req),
   .irq_id   (irq_id),
   .cur_level(cur_level)
);

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] dev_irq = '0;
   logic       nmi_irq = 1'b0;
   logic       en_wr = 1'b0;
   logic [4:0] en_data = '0;
   logic       swi_wr = 1'b0;
   logic       swi_val = 1'b0;
   logic       glob_dis = 1'b0;
   logic       ack = 1'b0;
   logic       rti = 1'b0;
   logic       irq_req;
   logic [2:0] irq_id;
   logic [3:0] cur_level;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   irq_prio_ctrl dut (
      .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .nmi_irq(nmi_irq),
      .en_wr(en_wr), .en_data(en_data), .swi_wr(swi_wr), .swi_val(swi_val),
      .glob_dis(glob_dis), .ack(ack), .rti(rti),
      .irq_req(irq_req), .irq_id(irq_id), .cur_level(cur_level)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // expects a presented request with the given id; -1 means none
   task automatic chk_req(input string tag, input int exp_id);
      if (exp_id < 0) chk({tag, " req"}, int'(irq_req), 0);
      else begin
         chk({tag, " req"}, int'(irq_req), 1);
         chk({tag, " id"}, int'(irq_id), exp_id);
      end
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic write_en(input logic [4:0] v);
      en_wr = 1'b1; en_data = v;
      @(negedge clk); en_wr = 1'b0; settle();
   endtask

   task automatic write_swi(input logic v);
      swi_wr = 1'b1; swi_val = v;
      @(negedge clk); swi_wr = 1'b0; settle();
   endtask

   task automatic pulse(input logic a, input logic r);
      ack = a; rti = r;
      @(negedge clk); ack = 1'b0; rti = 1'b0; settle();
   endtask

   task automatic t_reset();
      @(negedge clk); settle();
      chk("R1 level in reset", int'(cur_level), 0);
      chk_req("R1 in reset", -1);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); dev_irq = 4'hF; settle();
      chk_req("R1 lines high with enables clear", -1);
      chk("R1 level after reset", int'(cur_level), 0);
      dev_irq = '0;
   endtask

   task automatic t_mask();
      write_en(5'b11111);
      dev_irq = 4'b0001; settle();
      chk_req("R2 enabled line", 1);
      write_en(5'b11101);
      chk_req("R2 disabled line", -1);
      write_en(5'b11111);
      chk_req("R2 re-enabled line", 1);
      dev_irq = '0; settle();
      chk_req("R11 line dropped", -1);
   endtask

   task automatic t_prio();
      dev_irq = 4'b0101; settle();
      chk_req("R3 disk over network", 3);
      dev_irq = 4'b1111; settle();
      chk_req("R5 clock line id", 4);
      dev_irq = 4'b0010; settle();
      chk_req("R5 sound line id", 2);
      dev_irq = '0; settle();
   endtask

   task automatic t_swi();
      write_swi(1'b1);
      chk_req("R4 software set", 0);
      pulse(1'b1, 1'b0);
      chk("R9 software accept level", int'(cur_level), 1);
      chk_req("R8 own level blocked", -1);
      pulse(1'b0, 1'b1);
      chk("R10 back to zero", int'(cur_level), 0);
      chk_req("R4 still set after accept", 0);
      write_swi(1'b0);
      chk_req("R4 software cleared", -1);
   endtask

   task automatic t_disable();
      dev_irq = 4'hF; glob_dis = 1'b1; settle();
      chk_req("R6 global disable", -1);
      nmi_irq = 1'b1; settle();
      chk_req("R7 nmi through disable", 5);
      glob_dis = 1'b0; settle();
      chk_req("R7 nmi over clock", 5);
      nmi_irq = 1'b0; dev_irq = '0;
      write_en(5'b00000);
      nmi_irq = 1'b1; settle();
      chk_req("R7 nmi with enables clear", 5);
      nmi_irq = 1'b0;
      write_en(5'b11111);
   endtask

   task automatic t_nest();
      dev_irq = 4'b0001; settle();
      pulse(1'b1, 1'b0);
      chk("R9 network level", int'(cur_level), 3);
      chk_req("R8 same level blocked", -1);
      dev_irq = 4'b0011; settle();
      chk_req("R8 sound preempts", 2);
      pulse(1'b1, 1'b0);
      chk("R9 sound level", int'(cur_level), 5);
      chk_req("R8 lower levels blocked", -1);
      pulse(1'b1, 1'b0);
      chk("R9 ack without request", int'(cur_level), 5);
      pulse(1'b0, 1'b1);
      chk("R10 restore network level", int'(cur_level), 3);
      chk_req("R8 sound again presented", 2);
      pulse(1'b1, 1'b1);
      chk("R10 rti wins over ack", int'(cur_level), 0);
      pulse(1'b0, 1'b1);
      chk("R10 rti with empty stack", int'(cur_level), 0);
      dev_irq = '0; settle();
   endtask

   task automatic t_chain();
      write_swi(1'b1);
      pulse(1'b1, 1'b0);
      dev_irq = 4'b0001; settle(); pulse(1'b1, 1'b0);
      dev_irq = 4'b0011; settle(); pulse(1'b1, 1'b0);
      dev_irq = 4'b0111; settle(); pulse(1'b1, 1'b0);
      dev_irq = 4'b1111; settle(); pulse(1'b1, 1'b0);
      chk("R9 climbed to clock level", int'(cur_level), 7);
      nmi_irq = 1'b1; settle();
      chk_req("R7 nmi over clock handler", 5);
      pulse(1'b1, 1'b0);
      chk("R12 nmi level", int'(cur_level), 15);
      chk_req("R12 nothing at top level", -1);
      nmi_irq = 1'b0;
      pulse(1'b0, 1'b1); chk("R10 unwind 7", int'(cur_level), 7);
      pulse(1'b0, 1'b1); chk("R10 unwind 6", int'(cur_level), 6);
      pulse(1'b0, 1'b1); chk("R10 unwind 5", int'(cur_level), 5);
      pulse(1'b0, 1'b1); chk("R10 unwind 3", int'(cur_level), 3);
      pulse(1'b0, 1'b1); chk("R10 unwind 1", int'(cur_level), 1);
      pulse(1'b0, 1'b1); chk("R10 unwind 0", int'(cur_level), 0);
      chk_req("R3 clock presented after unwind", 4);
      dev_irq = '0;
      write_swi(1'b0);
      chk_req("R11 all quiet", -1);
   endtask

   initial begin
      t_reset();
      t_mask();
      t_prio();
      t_swi();
      t_disable();
      t_nest();
      t_chain();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule